// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-mapped master for the two-wire PHY management bus. Software stores one 32-bit command word in the frame register, and that write starts a frame at once; there is no separate go bit. The block first sends a preamble of 32 one bits. It then shifts the command word out MSB first on the data line, against a management clock that it derives from the system clock. The fields of the command word are laid out exactly as they appear on the wire, from the start code down to the data. For a read, the block releases the data line during turnaround, samples the 16 bits that the PHY returns, and puts them into the low half of the frame register. When a frame finishes, the block raises a completion bit in the event register. Software clears that bit by writing a one to it.

The management clock period is twice the divider value held in the speed register, counted in system clocks. Software normally loads the divider with the system clock in MHz divided by 5, which keeps the management clock at 2.5 MHz or below. A divider of zero stops the management clock, and any frame write is then dropped. The register bus is a plain write strobe with a combinational read port. The data line leaves the block as an output value plus an output enable, and the pad's pull-up returns a one whenever nothing drives the line.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset the frame, event and speed registers read zero, `mdc` is low, `mdio_oe` is low and `evt_done` is low.
- R2: With a nonzero divider, a write to the frame register (address 0) starts a frame. The frame is 32 one bits followed by the 32 command bits, bit 31 first, for 64 management clock periods in total.
- R3: `mdio_out` changes only on a falling edge of `mdc`, and each bit is sampled on the rising edge of `mdc`.
- R4: The divider D sits in bits [DIV_W:1] of the speed register (address 2). `mdc` has a period of 2*D system clocks and stays low when no frame is in progress.
- R5: A command whose bits 29:28 equal 2'b10 is a read. For a read, `mdio_oe` is low from frame bit index 47 (the second turnaround bit, where index 0 is the first preamble bit) through index 63. In every other bit of every frame it is high.
- R6: After a read, frame register bits 15:0 hold the 16 values sampled on `mdio_in` during indices 48..63, the first sampled value in bit 15, and bits 31:16 are unchanged. With no PHY present this gives 0xFFFF.
- R7: Bit 0 of the event register (address 1), mirrored on `evt_done`, is set when a frame ends. Bit 8 of the event register reads 1 while a frame is in progress.
- R8: Writing the event register with bit 0 set clears the completion bit, and writing all ones also clears it. Writing with bit 0 clear leaves it set.
- R9: A frame register write while a frame is in progress is ignored: the wire frame and the register contents are unchanged.
- R10: With a divider of 0, a frame register write is ignored. No frame starts, `mdc` does not toggle and the frame register keeps its value.
- R11: After a non-read frame, the frame register still holds the written command, and `mdio_oe` stays high for all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 frame, 1 event, 2 speed |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input from the pad |
| evt_done | output | 1 | Completion event flag |

## Verification
The situations hardest to reach from the ports are the bit at which the line is handed over during a read, and a second frame write that lands while a frame is still being sent. The bench runs a PHY responder from the `mdc` edges. It counts rising edges to find each bit index, checks the output enable at every edge, and drives the pad only from index 47 on. To cover the collision case, some frames get a conflicting frame write partway through, and the bench then compares the wire bits and the register contents against the first command.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  localparam int PRE_BITS = 32;
  localparam int CMD_BITS = 32;
  localparam logic [1:0] RA_FRAME = 2'd0;
  localparam logic [1:0] RA_EVENT = 2'd1;
  localparam logic [1:0] RA_SPEED = 2'd2;
  localparam int EVT_DONE_BIT = 0;
  localparam int EVT_BUSY_BIT = 8;
  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
  logic [DIV_W-1:0] cnt;
  logic hit;

  assign hit     = run && (cnt == div - ONE);
  assign rise_ev = hit && !mdc;
  assign fall_ev = hit && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (hit) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CMD_BITS-1:0] cmd,
  input  logic                rise_ev,
  input  logic                fall_ev,
  input  logic                mdio_in,
  output logic                busy,
  output logic                finish,
  output logic                is_read,
  output logic                mdio_out,
  output logic                mdio_oe,
  output logic [15:0]         rd_data
);
  localparam int TOTAL  = PRE_BITS + CMD_BITS;
  localparam int IDX_W  = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST     = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] TA_REL   = IDX_W'(PRE_BITS + 15);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 16);

  logic [TOTAL-1:0] sh;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      idx     <= '0;
      busy    <= 1'b0;
      is_read <= 1'b0;
      rd_data <= '0;
    end else if (start && !busy) begin
      sh      <= {{PRE_BITS{1'b1}}, cmd};
      idx     <= '0;
      busy    <= 1'b1;
      is_read <= (cmd[29:28] == OP_READ);
      rd_data <= '0;
    end else if (busy) begin
      if (rise_ev && idx >= DATA_IDX)
        rd_data <= {rd_data[14:0], mdio_in};
      if (fall_ev) begin
        if (idx == LAST) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sh  <= {sh[TOTAL-2:0], 1'b0};
        end
      end
    end
  end

  assign finish   = busy && fall_ev && (idx == LAST);
  assign mdio_out = sh[TOTAL-1];
  assign mdio_oe  = busy && !(is_read && idx >= TA_REL);
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_frame_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in,
  output logic        evt_done
);
  logic [31:0]      frame_q;
  logic             done_q;
  logic [DIV_W-1:0] div_q;
  logic             busy, finish, is_read, start, rise_ev, fall_ev;
  logic [15:0]      rd_data;

  assign start = reg_wr && (reg_addr == RA_FRAME) && !busy && (div_q != '0);

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(reg_wdata),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .mdio_in(mdio_in),
    .busy(busy), .finish(finish), .is_read(is_read),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      done_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      if (start)
        frame_q <= reg_wdata;
      else if (finish && is_read)
        frame_q[15:0] <= rd_data;
      if (reg_wr && reg_addr == RA_EVENT && reg_wdata[EVT_DONE_BIT])
        done_q <= 1'b0;
      if (finish)
        done_q <= 1'b1;
      if (reg_wr && reg_addr == RA_SPEED)
        div_q <= reg_wdata[DIV_W:1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_FRAME: reg_rdata = frame_q;
      RA_EVENT: begin
        reg_rdata[EVT_DONE_BIT] = done_q;
        reg_rdata[EVT_BUSY_BIT] = busy;
      end
      RA_SPEED: reg_rdata[DIV_W:1] = div_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign evt_done = done_q;
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy,
  input logic        done,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] frame_hi
);
  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_oe_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_data_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_out)) |-> $fell(mdc));

  assert_done_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd0) |=> (frame_hi == $past(frame_hi)));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
  .mdio_oe(mdio_oe), .busy(busy), .done(done_q), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .frame_hi(frame_q[31:16])
);

// File: tb/mdio_frame_ctrl_test.sv
`timescale 1ns/1ps
module mdio_frame_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_out, mdio_oe, evt_done;
  wire  mdio_in;

  int n_chk = 0, n_bad = 0;
  logic [63:0] obs;
  int   rise_cnt = 0, oe_err = 0, per_err = 0, cur_div = 1;
  logic cur_rd = 1'b0, phy_present = 1'b1, phy_en = 1'b0, phy_bit = 1'b1;
  logic [15:0] phy_data = '0;
  realtime last_t = 0;

  always #2.5 clk = ~clk;

  mdio_frame_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in), .evt_done(evt_done)
  );

  assign mdio_in = mdio_oe ? mdio_out : (phy_en ? phy_bit : 1'b1);

  always @(posedge mdc) begin
    if (rise_cnt < 64) obs[63 - rise_cnt] = mdio_out;
    if (mdio_oe != !(cur_rd && rise_cnt >= 47)) oe_err++;
    if (rise_cnt > 0 && ($realtime - last_t) != 5.0 * 2 * cur_div) per_err++;
    last_t = $realtime;
    rise_cnt++;
  end

  always @(negedge mdc) begin
    if (phy_present && cur_rd && rise_cnt == 47) begin
      phy_en = 1'b1; phy_bit = 1'b0;
    end else if (phy_present && cur_rd && rise_cnt >= 48 && rise_cnt <= 63) begin
      phy_en = 1'b1; phy_bit = phy_data[63 - rise_cnt];
    end else begin
      phy_en = 1'b0; phy_bit = 1'b1;
    end
  end

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] exp_frame(input logic [31:0] c, input logic pres,
                                            input logic [15:0] d);
    if (c[29:28] == 2'b10) return {c[31:16], pres ? d : 16'hFFFF};
    return c;
  endfunction

  task automatic run_frame(input logic [31:0] c, input int d, input logic pres,
                           input logic [15:0] data, input logic intrude);
    logic [31:0] v;
    int waited;
    if (d != cur_div) begin wr(2'd2, 32'(d) << 1); cur_div = d; end
    cur_rd = (c[29:28] == 2'b10); phy_present = pres; phy_data = data;
    rise_cnt = 0; oe_err = 0; per_err = 0; obs = '0;
    wr(2'd0, c);
    rd(2'd1, v);
    check({63'd0, v[8]}, 64'd1, "R7 busy bit during frame");
    if (intrude) begin
      repeat (30) @(negedge clk);
      wr(2'd0, ~c);
      rd(2'd0, v);
      check({32'd0, v}, {32'd0, c}, "R9 frame reg after busy write");
    end
    waited = 0;
    while (!evt_done && waited < 200 * d + 50) begin @(negedge clk); waited++; end
    check(64'(rise_cnt), 64'd64, "R2 mdc rising edges per frame");
    check(obs, {32'hFFFF_FFFF, c}, intrude ? "R9 wire frame after busy write" : "R2 R3 wire frame");
    check(64'(oe_err), 64'd0, cur_rd ? "R5 read oe release" : "R11 write oe held");
    check(64'(per_err), 64'd0, "R4 mdc period");
    rd(2'd0, v);
    check({32'd0, v}, {32'd0, exp_frame(c, pres, data)}, cur_rd ? "R6 read data" : "R11 frame reg kept");
    rd(2'd1, v);
    check({62'd0, evt_done, v[0]}, 64'd3, "R7 done set");
    check({63'd0, v[8]}, 64'd0, "R7 busy clear");
    wr(2'd1, 32'h1);
    rd(2'd1, v);
    check({63'd0, v[0]}, 64'd0, "R8 done cleared by write one");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check({32'd0, v}, 64'd0, "R1 frame reg reset");
    rd(2'd1, v); check({32'd0, v}, 64'd0, "R1 event reg reset");
    rd(2'd2, v); check({32'd0, v}, 64'd0, "R1 speed reg reset");
    check({61'd0, mdc, mdio_oe, evt_done}, 64'd0, "R1 pins reset");
    // R10 divider zero ignores frame write
    wr(2'd0, 32'h6002_0000);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check({32'd0, v}, 64'd0, "R10 frame reg unchanged");
    rd(2'd1, v); check({32'd0, v}, 64'd0, "R10 no busy no done");
    check(64'(rise_cnt), 64'd0, "R10 mdc idle");
    // R4 speed register field
    wr(2'd2, 32'h0000_0006); cur_div = 3;
    rd(2'd2, v); check({32'd0, v}, 64'h6, "R4 speed reg readback");
    // directed frames
    run_frame(32'h6002_0000, 3, 1'b1, 16'h1234, 1'b0);
    run_frame(32'h5002_BEEF, 2, 1'b1, 16'h0000, 1'b0);
    run_frame(32'h6002_0000 | (32'd31 << 23) | (32'd31 << 18), 1, 1'b0, 16'h0, 1'b0);
    run_frame(32'h6002_0000 | (32'd5 << 23), 2, 1'b1, 16'hA5C3, 1'b1);
    // R8 write zero keeps done, all ones clears
    wr(2'd0, 32'h5002_0001);
    while (!evt_done) @(negedge clk);
    wr(2'd1, 32'h0);
    rd(2'd1, v); check({63'd0, v[0]}, 64'd1, "R8 write zero keeps done");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); check({63'd0, v[0]}, 64'd0, "R8 all ones clears");
    // random frames
    for (int i = 0; i < 12; i++) begin
      logic [31:0] c;
      c = {2'b01, ($urandom % 2) ? 2'b10 : 2'b01, 5'($urandom), 5'($urandom), 2'b10, 16'($urandom)};
      run_frame(c, 1 + ($urandom % 4), ($urandom % 4) != 0, 16'($urandom), ($urandom % 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule